// File: doc/BRIEF.md
# GPIO Port Controller with Configuration Lock

This block controls a 16-pin general-purpose I/O port from a simple register bus. Every pin has a 4-bit configuration field that selects input or output operation and the pin's flavour: analog, floating or pulled input, or a push-pull or open-drain output that is driven either as plain GPIO or by an alternate function. From these fields and the output data register, the block drives per-pin output value, output enable, open-drain, alternate-function select, pull enable, pull direction and analog enable. Pin levels come back through a synchronizer and are readable at any time.

Software can change output bits atomically. The split set/clear register sets and clears bits in one write. The clear-only register clears them. Neither needs a read-modify-write. A key sequence of three writes and one read on the lock register freezes the configuration fields of the chosen pins until the next reset. The output data stays writable.

The bus is single-cycle. A write is captured at the rising clock edge where `busWrEn` is high. Read data is combinational and valid while `busRdEn` is high.

Top module: `gpio_lock_port`

## Requirements
- R1: After reset, both configuration registers read 0x44444444. The output data register and the lock register read 0. Every pin has output enable, pull enable, analog enable, open-drain and alternate select low.
- R2: The word address map is 0 low config, 1 high config, 2 input data, 3 output data, 4 set/clear, 5 clear-only and 6 lock. Pins 0–7 live in word 0 and pins 8–15 in word 1, at bit offset 4×(pin mod 8). In each field, MODE is bits [1:0] and CNF is bits [3:2]. Written fields read back unchanged. Unmapped and write-only words read 0.
- R3: With MODE non-zero, the pin has output enable high. CNF bit 0 set selects open-drain and CNF bit 1 set selects the alternate-function source.
- R4: With MODE 00, CNF 00 gives analog enable. CNF 10 gives pull enable, with pull direction up when the pin's output data bit is 1 and down when it is 0. CNF 01 and 11 give a floating input with no pull and no analog enable.
- R5: A write to word 3 replaces the output data register. Each pin's output value equals its output data bit.
- R6: A write to word 4 sets output bits where bits [15:0] are 1 and clears them where bits [31:16] are 1. A pin named in both halves ends up set. Pins with both bits 0 keep their value.
- R7: A write to word 5 clears the output bits where bits [15:0] are 1. Other output bits keep their value.
- R8: Word 2 returns the pin input levels two clock edges after they change, in every pin mode. Writes to word 2 change nothing.
- R9: Word 6 holds the key in bit 16 and the lock bits in [15:0]. Lock bits [15:0] read back the last lock bits written. The lock completes only after this order: a write with key 1, then a write with key 0, then a write with key 1, all three with the same lock bits, and then a read of word 6. After that read, bit 16 reads 1.
- R10: While locked, the configuration fields of pins whose lock bit is 1 ignore writes. Fields of other pins and the output data stay writable.
- R11: A key sequence that breaks the order or changes the lock bits does not lock. Bit 16 stays 0 and configuration stays writable.
- R12: Once locked, writes to word 6 change neither the key bit nor the lock bits until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe |
| busAddr | input | 3 | Word address |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, zero when no read |
| padIn | input | 16 | Pin input levels (asynchronous) |
| padOut | output | 16 | Per-pin output value |
| padOe | output | 16 | Per-pin output enable |
| padOd | output | 16 | Per-pin open-drain select |
| afSel | output | 16 | Per-pin alternate-function select |
| pullEn | output | 16 | Per-pin pull enable |
| pullUp | output | 16 | Per-pin pull direction, 1 = up |
| analogEn | output | 16 | Per-pin analog mode |

## Verification
Directed patterns drive configuration words that place a different mode in each nibble. These show whether pin fields land at the right offset and in the right register, and whether MODE and CNF decode separately. A set/clear write that names the same pins in both halves, next to pins named in neither, separates set-wins priority from untouched bits. Key sequences with a changed lock-bit value and with a misplaced key bit are kept apart from the correct sequence, so that an aborted lock and a real lock can be told apart. A write to every configuration field after locking then shows which pins froze. Seeded random mixes of configuration, output and input traffic, each followed by a full register and pin comparison, cover combinations that the directed cases miss, both before and after locking.

// File: rtl/gpio_lock_pkg.sv
package gpio_lock_pkg;
  localparam int PIN_COUNT    = 16;
  localparam int BUS_W        = 2 * PIN_COUNT;
  localparam int FIELD_W      = 4;
  localparam int PINS_PER_CFG = BUS_W / FIELD_W;
  localparam int CFG_REGS     = PIN_COUNT / PINS_PER_CFG;
  localparam int CFG_SEL_W    = (CFG_REGS > 1) ? $clog2(CFG_REGS) : 1;
  localparam int ADDR_W       = 3;
  localparam int KEY_BIT      = PIN_COUNT;
  localparam logic [FIELD_W-1:0] CFG_RESET = 4'h4;

  typedef enum logic [ADDR_W-1:0] {
    ADR_CFG_LO = 3'd0,
    ADR_CFG_HI = 3'd1,
    ADR_IN     = 3'd2,
    ADR_OUT    = 3'd3,
    ADR_SETCLR = 3'd4,
    ADR_CLR    = 3'd5,
    ADR_LOCK   = 3'd6
  } reg_addr_e;

  typedef enum logic [2:0] {
    LK_IDLE, LK_ONE, LK_ZERO, LK_ARMED, LK_DONE
  } lock_state_e;

  typedef struct packed {
    logic                 cfgWr;
    logic [CFG_SEL_W-1:0] cfgSel;
    logic                 odrWr;
    logic                 bsrWr;
    logic                 brWr;
    logic                 locked;
    logic [PIN_COUNT-1:0] lockMask;
  } strobe_t;
endpackage

// File: rtl/gpio_lock_ctrl.sv
module gpio_lock_ctrl
  import gpio_lock_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busWrEn,
  input  logic                 busRdEn,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 keyIn,
  input  logic [PIN_COUNT-1:0] lockBitsIn,
  output strobe_t              strb
);
  lock_state_e lockState, lockNext;
  logic [PIN_COUNT-1:0] lockBitsQ;
  logic lockWr, lockRd, sameBits;

  assign lockWr   = busWrEn && (busAddr == ADR_LOCK);
  assign lockRd   = busRdEn && (busAddr == ADR_LOCK);
  assign sameBits = (lockBitsIn == lockBitsQ);

  // key sequence: 1, 0, 1 with equal bits, then a read
  always_comb begin
    lockNext = lockState;
    if (lockState != LK_DONE) begin
      if (lockWr) begin
        if (keyIn)
          lockNext = (lockState == LK_ZERO && sameBits) ? LK_ARMED : LK_ONE;
        else
          lockNext = (lockState == LK_ONE && sameBits) ? LK_ZERO : LK_IDLE;
      end else if (lockRd && lockState == LK_ARMED) begin
        lockNext = LK_DONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockState <= LK_IDLE;
      lockBitsQ <= '0;
    end else begin
      lockState <= lockNext;
      if (lockWr && lockState != LK_DONE) lockBitsQ <= lockBitsIn;
    end
  end

  always_comb begin
    strb.cfgWr    = busWrEn && (int'(busAddr) < CFG_REGS);
    strb.cfgSel   = busAddr[CFG_SEL_W-1:0];
    strb.odrWr    = busWrEn && (busAddr == ADR_OUT);
    strb.bsrWr    = busWrEn && (busAddr == ADR_SETCLR);
    strb.brWr     = busWrEn && (busAddr == ADR_CLR);
    strb.locked   = (lockState == LK_DONE);
    strb.lockMask = lockBitsQ;
  end

  // R12
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.locked |=> strb.locked);
  // R12
  lock_bits_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.locked |=> $stable(lockBitsQ));
  // R9
  lock_by_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.locked && lockRd && lockState == LK_ARMED) |=> strb.locked);
  // R2
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.cfgWr, strb.odrWr, strb.bsrWr, strb.brWr}));
endmodule

// File: rtl/gpio_lock_dp.sv
module gpio_lock_dp
  import gpio_lock_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strb,
  input  logic                 busRdEn,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [BUS_W-1:0]     busWrData,
  output logic [BUS_W-1:0]     busRdData,
  input  logic [PIN_COUNT-1:0] padIn,
  output logic [PIN_COUNT-1:0] padOut,
  output logic [PIN_COUNT-1:0] padOe,
  output logic [PIN_COUNT-1:0] padOd,
  output logic [PIN_COUNT-1:0] afSel,
  output logic [PIN_COUNT-1:0] pullEn,
  output logic [PIN_COUNT-1:0] pullUp,
  output logic [PIN_COUNT-1:0] analogEn
);
  logic [PIN_COUNT-1:0][FIELD_W-1:0] cfgQ;
  logic [PIN_COUNT-1:0] odrQ;
  logic [PIN_COUNT-1:0] syncQ [SYNC_STAGES];
  logic [BUS_W-1:0] cfgWord [CFG_REGS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int p = 0; p < PIN_COUNT; p++) cfgQ[p] <= CFG_RESET;
    end else if (strb.cfgWr) begin
      for (int p = 0; p < PIN_COUNT; p++)
        if (int'(strb.cfgSel) == p / PINS_PER_CFG && !(strb.locked && strb.lockMask[p]))
          cfgQ[p] <= busWrData[(p % PINS_PER_CFG) * FIELD_W +: FIELD_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            odrQ <= '0;
    else if (strb.odrWr)  odrQ <= busWrData[PIN_COUNT-1:0];
    else if (strb.bsrWr)  odrQ <= (odrQ & ~busWrData[BUS_W-1:PIN_COUNT]) | busWrData[PIN_COUNT-1:0];
    else if (strb.brWr)   odrQ <= odrQ & ~busWrData[PIN_COUNT-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncQ[s] <= '0;
    end else begin
      syncQ[0] <= padIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
    end
  end

  always_comb begin
    for (int r = 0; r < CFG_REGS; r++)
      for (int i = 0; i < PINS_PER_CFG; i++)
        cfgWord[r][i*FIELD_W +: FIELD_W] = cfgQ[r*PINS_PER_CFG + i];
  end

  always_comb begin
    busRdData = '0;
    if (busRdEn) begin
      if (int'(busAddr) < CFG_REGS) busRdData = cfgWord[busAddr[CFG_SEL_W-1:0]];
      else if (busAddr == ADR_IN)   busRdData[PIN_COUNT-1:0] = syncQ[SYNC_STAGES-1];
      else if (busAddr == ADR_OUT)  busRdData[PIN_COUNT-1:0] = odrQ;
      else if (busAddr == ADR_LOCK) busRdData[KEY_BIT:0] = {strb.locked, strb.lockMask};
    end
  end

  always_comb begin
    for (int p = 0; p < PIN_COUNT; p++) begin
      padOut[p]   = odrQ[p];
      padOe[p]    = (cfgQ[p][1:0] != 2'b00);
      padOd[p]    = padOe[p] && cfgQ[p][2];
      afSel[p]    = padOe[p] && cfgQ[p][3];
      pullEn[p]   = !padOe[p] && (cfgQ[p][3:2] == 2'b10);
      pullUp[p]   = pullEn[p] && odrQ[p];
      analogEn[p] = !padOe[p] && (cfgQ[p][3:2] == 2'b00);
    end
  end

  // R6
  set_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.bsrWr |=> ((odrQ & $past(busWrData[PIN_COUNT-1:0])) == $past(busWrData[PIN_COUNT-1:0])));
  // R7
  clear_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.brWr |=> ((odrQ & $past(busWrData[PIN_COUNT-1:0])) == '0));
  // R4
  pull_vs_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pullEn & padOe) == '0);

  for (genvar g = 0; g < PIN_COUNT; g++) begin : g_lockChk
    // R10
    locked_field_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strb.locked && strb.lockMask[g]) |=> $stable(cfgQ[g]));
  end
endmodule

// File: rtl/gpio_lock_port.sv
module gpio_lock_port
  import gpio_lock_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWrEn,
  input  logic        busRdEn,
  input  logic [2:0]  busAddr,
  input  logic [31:0] busWrData,
  output logic [31:0] busRdData,
  input  logic [15:0] padIn,
  output logic [15:0] padOut,
  output logic [15:0] padOe,
  output logic [15:0] padOd,
  output logic [15:0] afSel,
  output logic [15:0] pullEn,
  output logic [15:0] pullUp,
  output logic [15:0] analogEn
);
  strobe_t strb;

  gpio_lock_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .keyIn(busWrData[KEY_BIT]),
    .lockBitsIn(busWrData[PIN_COUNT-1:0]), .strb(strb)
  );

  gpio_lock_dp #(.SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .padIn(padIn), .padOut(padOut), .padOe(padOe), .padOd(padOd),
    .afSel(afSel), .pullEn(pullEn), .pullUp(pullUp), .analogEn(analogEn)
  );
endmodule

// File: tb/gpio_lock_port_tb_top.sv
module gpio_lock_port_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWrEn = 1'b0, busRdEn = 1'b0;
  logic [2:0] busAddr = '0;
  logic [31:0] busWrData = '0, busRdData;
  logic [15:0] padIn = '0;
  logic [15:0] padOut, padOe, padOd, afSel, pullEn, pullUp, analogEn;

  int checks = 0, errors = 0;
  logic [3:0] mCfg [16];
  logic [15:0] mOdr, mIn, mLockBits, mMask;
  logic mLocked;

  always #10 clk = ~clk;

  gpio_lock_port dut_i (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .padIn(padIn), .padOut(padOut), .padOe(padOe), .padOd(padOd),
    .afSel(afSel), .pullEn(pullEn), .pullUp(pullUp), .analogEn(analogEn)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] cfgWordOf(input int r);
    logic [31:0] w;
    for (int i = 0; i < 8; i++) w[i*4 +: 4] = mCfg[r*8 + i];
    return w;
  endfunction

  task automatic busWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
    case (a)
      3'd0, 3'd1: for (int i = 0; i < 8; i++)
        if (!(mLocked && mMask[a*8 + i])) mCfg[a*8 + i] = d[i*4 +: 4];
      3'd3: mOdr = d[15:0];
      3'd4: mOdr = (mOdr & ~d[31:16]) | d[15:0];
      3'd5: mOdr = mOdr & ~d[15:0];
      3'd6: if (!mLocked) mLockBits = d[15:0];
      default: ;
    endcase
  endtask

  task automatic busRead(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    busRdEn = 1'b1; busAddr = a;
    #2 d = busRdData;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic checkAll(input string tag);
    logic [31:0] d;
    logic [15:0] eOe, eOd, eAf, ePe, ePu, eAn;
    busRead(3'd0, d); chk({tag, " R2 cfg lo"}, d, cfgWordOf(0));
    busRead(3'd1, d); chk({tag, " R2 cfg hi"}, d, cfgWordOf(1));
    busRead(3'd2, d); chk({tag, " R8 input"}, d, {16'h0, mIn});
    busRead(3'd3, d); chk({tag, " R5 odr"}, d, {16'h0, mOdr});
    busRead(3'd6, d); chk({tag, " R9 lock"}, d, {15'h0, mLocked, mLockBits});
    busRead(3'd7, d); chk({tag, " R2 unmapped"}, d, 32'h0);
    for (int p = 0; p < 16; p++) begin
      eOe[p] = mCfg[p][1:0] != 2'b00;
      eOd[p] = eOe[p] && mCfg[p][2];
      eAf[p] = eOe[p] && mCfg[p][3];
      ePe[p] = !eOe[p] && mCfg[p][3:2] == 2'b10;
      ePu[p] = ePe[p] && mOdr[p];
      eAn[p] = !eOe[p] && mCfg[p][3:2] == 2'b00;
    end
    chk({tag, " R5 padOut"}, {16'h0, padOut}, {16'h0, mOdr});
    chk({tag, " R3 padOe"}, {16'h0, padOe}, {16'h0, eOe});
    chk({tag, " R3 padOd"}, {16'h0, padOd}, {16'h0, eOd});
    chk({tag, " R3 afSel"}, {16'h0, afSel}, {16'h0, eAf});
    chk({tag, " R4 pullEn"}, {16'h0, pullEn}, {16'h0, ePe});
    chk({tag, " R4 pullUp"}, {16'h0, pullUp}, {16'h0, ePu});
    chk({tag, " R4 analogEn"}, {16'h0, analogEn}, {16'h0, eAn});
  endtask

  task automatic setPads(input logic [15:0] v);
    @(negedge clk);
    padIn = v;
    mIn = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic randomOps(input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      logic [31:0] r;
      r = $urandom;
      case ($urandom % 6)
        0: busWrite(3'd0, r);
        1: busWrite(3'd1, r);
        2: busWrite(3'd3, r);
        3: busWrite(3'd4, r);
        4: busWrite(3'd5, r);
        default: setPads(r[15:0]);
      endcase
      checkAll(tag);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5EED_0042));
    for (int p = 0; p < 16; p++) mCfg[p] = 4'h4;
    mOdr = '0; mIn = '0; mLockBits = '0; mMask = '0; mLocked = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    busRead(3'd0, d); chk("R1 cfg lo reset", d, 32'h44444444);
    busRead(3'd1, d); chk("R1 cfg hi reset", d, 32'h44444444);
    checkAll("R1");

    // R2 R3 R4: each nibble a different mode
    busWrite(3'd0, 32'hFB73_8C40);
    busWrite(3'd1, 32'h2519_E6D0);
    checkAll("R2/R3");
    busWrite(3'd3, 32'h0000_A5A5);     // R4 pull direction from odr
    busWrite(3'd0, 32'h8888_8888);
    checkAll("R4");

    // R6 set wins, untouched bits kept
    busWrite(3'd3, 32'h0000_F00F);
    busWrite(3'd4, 32'h0FF0_00FF);
    busRead(3'd3, d); chk("R6 set wins", d, 32'h0000_F0FF);
    busWrite(3'd4, 32'hFFFF_0000);
    busRead(3'd3, d); chk("R6 clear half", d, 32'h0);
    // R7
    busWrite(3'd3, 32'h0000_FFFF);
    busWrite(3'd5, 32'hFFFF_0F0F);
    busRead(3'd3, d); chk("R7 clear only", d, 32'h0000_F0F0);
    checkAll("R6/R7");

    // R8 input sync and ignored writes
    @(negedge clk); padIn = 16'hA5C3;
    busRead(3'd2, d); chk("R8 not yet after one edge", d, 32'h0);
    @(negedge clk); mIn = 16'hA5C3;
    busWrite(3'd2, 32'h1234_5678);
    busRead(3'd2, d); chk("R8 input after sync", d, 32'h0000_A5C3);
    checkAll("R8");

    randomOps(150, "rand pre-lock");

    // R11 aborts: changed bits, then misplaced key
    busWrite(3'd6, 32'h0001_00FF);
    busWrite(3'd6, 32'h0000_00FE);
    busWrite(3'd6, 32'h0001_00FF);
    busRead(3'd6, d); chk("R11 changed bits no lock", d, 32'h0000_00FF);
    busWrite(3'd6, 32'h0001_1234);
    busWrite(3'd6, 32'h0000_1234);
    busWrite(3'd6, 32'h0000_1234);
    busRead(3'd6, d); chk("R11 bad key no lock", d, 32'h0000_1234);
    busWrite(3'd0, 32'h1111_1111);
    busRead(3'd0, d); chk("R11 cfg still writable", d, 32'h1111_1111);

    // R9 correct sequence
    busWrite(3'd6, 32'h0001_8101);
    busWrite(3'd6, 32'h0000_8101);
    busWrite(3'd6, 32'h0001_8101);
    busRead(3'd6, d);
    mLocked = 1'b1; mMask = 16'h8101;
    busRead(3'd6, d); chk("R9 key reads one", d, 32'h0001_8101);

    // R10 locked pins frozen
    busWrite(3'd0, 32'h3333_3333);
    busWrite(3'd1, 32'h3333_3333);
    busRead(3'd0, d); chk("R10 cfg lo", d, 32'h3333_3331);
    busWrite(3'd3, 32'h0000_0101);
    busRead(3'd3, d); chk("R10 odr writable", d, 32'h0000_0101);
    checkAll("R10");

    // R12 lock writes ignored
    busWrite(3'd6, 32'h0000_0000);
    busWrite(3'd6, 32'h0001_FFFF);
    busRead(3'd6, d); chk("R12 lock unchanged", d, 32'h0001_8101);

    randomOps(100, "rand post-lock");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule